// File: doc/BRIEF.md
# Dual-View Port Interrupt Status Unit

This block collects twelve per-port event sources and keeps one sticky flag for each of them. A single status word shows every flag twice. The upper half holds the raw flags. The lower half holds the same flags ANDed with their enables. Software can acknowledge an event by writing a one to either copy. The events are: command done, command error, port ready, power-state change, PHY-ready change, wake signal seen, unknown frame type, device swapped, and three error-counter threshold crossings (decode, CRC, handshake), plus a set-device-bits notification.

The enable mask is written through two addresses. One sets enable bits, the other clears them, and both read back the current mask. A 2-bit routing field, written along with the set address, picks which of four interrupt lines carries the port's level interrupt. In automatic mode, a read of the separate slot-status register acknowledges the command-done event. A manual mode bit turns this off, so that only an explicit write-one clear removes it. Register reads are combinational. Writes and event captures take effect at the next clock edge.

Top module: `port_irq_status`

## Requirements
- R1: After reset all event flags, enables and the routing field are zero and every interrupt line is low.
- R2: A high bit i of `evt_in` sets raw flag i, which shows at status bit 16+i from the next cycle and stays set until cleared.
- R3: Reading address 0 returns raw flags in bits 27:16 and raw AND enable in bits 11:0, in the same event order (bit 0 command done, bit 1 error, bit 2 ready, bit 3 power change, bit 4 PHY-ready change, bit 5 wake, bit 6 unknown frame, bit 7 device swapped, bits 8-10 decode/CRC/handshake thresholds, bit 11 notify). Bits 15:12 and 31:28 read zero.
- R4: Writing address 0 with bit 16+i high clears flag i.
- R5: Writing address 0 with bit i high clears flag i, whether or not its enable is set.
- R6: An event arriving in the same cycle as any clear of its flag wins, and the flag stays set.
- R7: Writing address 1 ORs `wdata[11:0]` into the enable mask. Reading address 1 or address 2 returns the mask in bits 11:0. Address 3 reads zero.
- R8: Writing address 2 clears the enable bits where `wdata[11:0]` is high.
- R9: A write to address 1 loads the routing field from `wdata[31:30]`. A write to address 2 leaves the field unchanged. The field reads back at bits 31:30 of addresses 1 and 2 and never appears in the status word.
- R10: Line n (n = routing field) is high exactly when any masked flag is set. All other lines stay low.
- R11: With `cc_manual` low, a `slot_rd` pulse clears the command-done flag (bit 0) and leaves the other flags alone.
- R12: With `cc_manual` high, `slot_rd` has no effect, and command done is cleared only by a write-one to status bit 0 or bit 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 12 | Event pulses, one per source |
| cc_manual | input | 1 | 1 = command done needs an explicit clear |
| slot_rd | input | 1 | Strobe: slot-status register is being read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 enable-set, 2 enable-clear, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_line | output | 4 | Level interrupt lines, one selected by routing |

## Verification
The hardest case to reach is a collision on one flag in one cycle: a new event arrives together with an acknowledge. The acknowledge can come from the raw copy, the masked copy, or a slot-status read in automatic mode. The stimulus drives each of these pairs on purpose, then reads the status word on the next cycle to show that the flag survived. A second case needs the manual mode bit and the slot-status strobe to line up while command done is pending. The sequence holds command done, toggles the mode bit, and shows that the same strobe clears the flag in one mode and leaves it in the other.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int DATA_W    = 32;
  localparam int RAW_LSB   = 16;
  localparam int STEER_LSB = 30;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_EN_SET = 2'd1,
    SEL_EN_CLR = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // event positions (behavioural order, shared by both views)
  localparam int EV_CMD_DONE = 0;
  localparam int EV_CMD_ERR  = 1;
  localparam int EV_READY    = 2;
  localparam int EV_PWR_CHG  = 3;
  localparam int EV_PHY_CHG  = 4;
  localparam int EV_WAKE     = 5;
  localparam int EV_BAD_FRM  = 6;
  localparam int EV_DEV_SWAP = 7;
  localparam int EV_DEC_THR  = 8;
  localparam int EV_CRC_THR  = 9;
  localparam int EV_HSK_THR  = 10;
  localparam int EV_NOTIFY   = 11;
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int NUM_EVT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] clr_mask,
  output logic [NUM_EVT-1:0] raw_q
);
  // set dominates clear, per bit
  function automatic logic [NUM_EVT-1:0] next_flags(
    input logic [NUM_EVT-1:0] cur,
    input logic [NUM_EVT-1:0] set_v,
    input logic [NUM_EVT-1:0] clr_v
  );
    return set_v | (cur & ~clr_v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= next_flags(raw_q, evt_in, clr_mask);
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int NUM_EVT = 12,
  parameter int STEER_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_stb,
  input  logic               clr_stb,
  input  logic [NUM_EVT-1:0] bits_in,
  input  logic [STEER_W-1:0] steer_in,
  output logic [NUM_EVT-1:0] en_q,
  output logic [STEER_W-1:0] steer_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      steer_q <= '0;
    end else if (set_stb) begin
      en_q    <= en_q | bits_in;
      steer_q <= steer_in;
    end else if (clr_stb) begin
      en_q    <= en_q & ~bits_in;
    end
  end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
  parameter int NUM_EVT   = 12,
  parameter int NUM_LINES = 4,
  parameter int STEER_W   = 2
) (
  input  logic [NUM_EVT-1:0]   raw_q,
  input  logic [NUM_EVT-1:0]   en_q,
  input  logic [STEER_W-1:0]   steer_q,
  output logic [NUM_LINES-1:0] irq_line
);
  function automatic logic any_masked(
    input logic [NUM_EVT-1:0] r,
    input logic [NUM_EVT-1:0] e
  );
    return |(r & e);
  endfunction

  logic pending;
  assign pending = any_masked(raw_q, en_q);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign irq_line[g] = pending && (steer_q == STEER_W'(g));
  end
endmodule

// File: rtl/port_irq_status.sv
module port_irq_status
  import irq_stat_pkg::*;
#(
  parameter int NUM_EVT   = 12,
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_in,
  input  logic                 cc_manual,
  input  logic                 slot_rd,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] irq_line
);
  localparam int STEER_W = $clog2(NUM_LINES);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  // named internal events for the checker
  logic               st_wr, set_wr, clr_wr, auto_cc;
  logic [NUM_EVT-1:0] clr_mask, raw_q, en_q;
  logic [STEER_W-1:0] steer_q;
  logic               wdata_unused;

  assign st_wr   = reg_wr && (sel == SEL_STATUS);
  assign set_wr  = reg_wr && (sel == SEL_EN_SET);
  assign clr_wr  = reg_wr && (sel == SEL_EN_CLR);
  assign auto_cc = slot_rd && !cc_manual;
  assign wdata_unused = ^reg_wdata;

  // a one in either view acknowledges the event
  function automatic logic [NUM_EVT-1:0] fold_w1c(input logic [DATA_W-1:0] w);
    return w[NUM_EVT-1:0] | w[RAW_LSB +: NUM_EVT];
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(
    input logic [NUM_EVT-1:0] r,
    input logic [NUM_EVT-1:0] e
  );
    logic [DATA_W-1:0] v;
    v = '0;
    v[RAW_LSB +: NUM_EVT] = r;
    v[0 +: NUM_EVT]       = r & e;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_enable(
    input logic [NUM_EVT-1:0] e,
    input logic [STEER_W-1:0] s
  );
    logic [DATA_W-1:0] v;
    v = '0;
    v[0 +: NUM_EVT]         = e;
    v[STEER_LSB +: STEER_W] = s;
    return v;
  endfunction

  always_comb begin
    clr_mask = st_wr ? fold_w1c(reg_wdata) : '0;
    if (auto_cc) clr_mask[EV_CMD_DONE] = 1'b1;
  end

  irq_evt_bank #(.NUM_EVT(NUM_EVT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_in),
    .clr_mask (clr_mask),
    .raw_q    (raw_q)
  );

  irq_en_reg #(.NUM_EVT(NUM_EVT), .STEER_W(STEER_W)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_stb  (set_wr),
    .clr_stb  (clr_wr),
    .bits_in  (reg_wdata[NUM_EVT-1:0]),
    .steer_in (reg_wdata[STEER_LSB +: STEER_W]),
    .en_q     (en_q),
    .steer_q  (steer_q)
  );

  irq_line_router #(.NUM_EVT(NUM_EVT), .NUM_LINES(NUM_LINES), .STEER_W(STEER_W)) u_route (
    .raw_q    (raw_q),
    .en_q     (en_q),
    .steer_q  (steer_q),
    .irq_line (irq_line)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata = pack_status(raw_q, en_q);
      SEL_EN_SET,
      SEL_EN_CLR: reg_rdata = pack_enable(en_q, steer_q);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker #(
  parameter int NUM_EVT   = 12,
  parameter int NUM_LINES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_EVT-1:0]   evt_in,
  input logic [NUM_EVT-1:0]   clr_mask,
  input logic                 slot_rd,
  input logic                 cc_manual,
  input logic [NUM_EVT-1:0]   raw_q,
  input logic [NUM_EVT-1:0]   en_q,
  input logic [NUM_LINES-1:0] irq_line
);
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((raw_q & $past(evt_in)) == $past(evt_in))); // R6

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(evt_in)) == '0)); // R2

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~evt_in) != '0) |=> ((raw_q & $past(clr_mask & ~evt_in)) == '0)); // R4

  AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cc_manual && slot_rd && !evt_in[0]) |=> !raw_q[0]); // R11

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_manual && raw_q[0] && !clr_mask[0]) |=> raw_q[0]); // R12

  AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_line)); // R10

  AST_LINE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_line) == (|(raw_q & en_q))); // R10
endmodule

bind port_irq_status irq_status_checker #(.NUM_EVT(NUM_EVT), .NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_in    (evt_in),
  .clr_mask  (clr_mask),
  .slot_rd   (slot_rd),
  .cc_manual (cc_manual),
  .raw_q     (raw_q),
  .en_q      (en_q),
  .irq_line  (irq_line)
);

// File: tb/test_port_irq_status.sv
module test_port_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt_in = '0;
  logic        cc_manual = 1'b0;
  logic        slot_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_line;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  bit m_raw [12];
  bit m_en  [12];
  int m_steer = 0;

  always #2 clk = ~clk;

  port_irq_status i_port_irq_status (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cc_manual(cc_manual),
    .slot_rd(slot_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(irq_line)
  );

  function automatic logic [31:0] exp_read(input int a);
    logic [31:0] v;
    v = '0;
    if (a == 0) begin
      for (int i = 0; i < 12; i++) begin
        v[16 + i] = m_raw[i];
        v[i]      = m_raw[i] && m_en[i];
      end
    end else if (a == 1 || a == 2) begin
      for (int i = 0; i < 12; i++) v[i] = m_en[i];
      v[31:30] = 2'(m_steer);
    end
    return v;
  endfunction

  function automatic logic [3:0] exp_lines();
    bit any;
    any = 0;
    for (int i = 0; i < 12; i++) if (m_raw[i] && m_en[i]) any = 1;
    return any ? (4'b1 << m_steer) : 4'b0;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive one cycle, check combinational outputs, then advance model
  task automatic step(input logic [11:0] ev, input logic wr, input logic [1:0] a,
                      input logic [31:0] wd, input logic srd, input logic man,
                      input string tag);
    @(negedge clk);
    evt_in = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    slot_rd = srd; cc_manual = man;
    #1;
    check32({tag, " rdata"}, reg_rdata, exp_read(a));
    check32({tag, " irq"}, {28'b0, irq_line}, {28'b0, exp_lines()});
    @(posedge clk);
    for (int i = 0; i < 12; i++) begin
      bit clr;
      clr = wr && a == 2'd0 && (wd[i] || wd[16 + i]);
      if (i == 0 && srd && !man) clr = 1;
      m_raw[i] = ev[i] || (m_raw[i] && !clr);
      if (wr && a == 2'd1 && wd[i]) m_en[i] = 1;
      if (wr && a == 2'd2 && wd[i]) m_en[i] = 0;
    end
    if (wr && a == 2'd1) m_steer = int'(wd[31:30]);
    #0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) begin m_raw[i] = 0; m_en[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_addr = 2'd0; #1;
    check32("R1 status in reset", reg_rdata, 32'h0);
    check32("R1 lines in reset", {28'b0, irq_line}, 32'h0);
    reg_addr = 2'd1; #1;
    check32("R1 enable in reset", reg_rdata, 32'h0);
    rst_n = 1'b1;

    step(12'h021, 0, 2'd0, 0, 0, 0, "R2 pulse bits 0,5");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R2 flags visible");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R2 flags sticky");
    step(12'h000, 1, 2'd1, 32'h8000_0021, 0, 0, "R7 R9 enable-set with route 2");
    step(12'h000, 0, 2'd1, 0, 0, 0, "R7 R9 read at set address");
    step(12'h000, 0, 2'd2, 0, 0, 0, "R7 R9 read at clear address");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R3 R10 masked view and line 2");
    step(12'h000, 1, 2'd0, 32'h0020_0000, 0, 0, "R4 clear via raw bit 21");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R4 bit 5 gone");
    step(12'h080, 0, 2'd0, 0, 0, 0, "R2 unmasked event 7");
    step(12'h000, 1, 2'd0, 32'h0000_0080, 0, 0, "R5 clear disabled bit via masked pos");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R5 bit 7 gone");
    step(12'h008, 1, 2'd0, 32'h0008_0008, 0, 0, "R6 event and clear same cycle");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R6 bit 3 kept");
    step(12'h000, 1, 2'd2, 32'hC000_0001, 0, 0, "R8 R9 enable-clear bit 0");
    step(12'h000, 0, 2'd2, 0, 0, 0, "R8 R9 mask and route after clear");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R10 line low after disable");
    step(12'h000, 1, 2'd1, 32'hC000_0009, 0, 0, "R9 route to 3 and enable 0,3");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R10 line 3");
    step(12'h000, 0, 2'd0, 0, 1, 0, "R11 slot read auto-clear");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R11 bit 0 gone bit 3 kept");
    step(12'h001, 0, 2'd0, 0, 1, 0, "R6 event wins over auto-clear");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R6 bit 0 kept");
    step(12'h000, 0, 2'd0, 0, 1, 1, "R12 manual slot read ignored");
    step(12'h000, 0, 2'd0, 0, 0, 1, "R12 bit 0 still set");
    step(12'h000, 1, 2'd0, 32'h0000_0001, 0, 1, "R12 explicit clear");
    step(12'h000, 0, 2'd0, 0, 0, 1, "R12 bit 0 gone");
    step(12'hFFF, 1, 2'd1, 32'h4000_0FFF, 0, 0, "R2 R7 all events, all enables, route 1");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R3 R10 full word and line 1");
    step(12'h000, 0, 2'd3, 0, 0, 0, "R7 unused address reads zero");
    step(12'h000, 1, 2'd0, 32'hFFFF_FFFF, 0, 0, "R4 R5 clear all");
    step(12'h000, 0, 2'd0, 0, 0, 0, "R4 all gone, lines low");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule